// File: doc/BRIEF.md
# Flash Descriptor Chain Sequencer

This block walks a linked list of descriptors held in system memory on behalf of a NAND flash controller. The host starts a chain by presenting three command words. The first word carries a mode field and a thread number. The other two words give the head descriptor address. The block fetches each descriptor as a single burst of 64-bit words and decodes its command type and flags. It then hands an abstract operation (erase, reset, copyback, program or read) to a downstream command engine. The flash and memory pointers it sends are already resolved.

When the engine reports a result, the block builds a status word and writes it into the descriptor. If the descriptor asks for it, the block raises a completion interrupt on the chain's thread line. It then follows the next pointer while the descriptor's continue flag is set.

Three kinds of descriptor never reach the engine. A descriptor already marked complete is skipped without any write. A no-operation descriptor is completed directly. A descriptor with an unknown command is marked in error and ends the chain. Per-descriptor flags let an operation resume from the flash and memory addresses where the previous operation ended. The flash timing, ECC and data movement belong to the engine and appear here only as a handshake with a result.

Top module: `flash_desc_seq`

## Requirements
- R1: A command with `cmd_valid_i` high while idle and `cmd0_i[31:30]` equal to 2'b00 starts a chain at the address `{cmd3_i, cmd2_i}`, with the thread number taken from `cmd0_i[26:24]`. Any other mode value is ignored, and `busy_o` stays low.
- R2: Each descriptor is fetched with one read request at the descriptor address, followed by 8 data beats. Beat 0 is the next pointer. Beat 1 holds the flash pointer in [31:0] and the bank in [47:32]. Beat 2 holds the command type in [15:0] and the flags in [47:32]. Beat 3 is the memory pointer and beat 4 is the status. The request and its address hold until `rd_ack_i`.
- R3: The command type upper byte selects the engine operation on `op_kind_o`: 0x10 erase=0, 0x11 reset=1, 0x12 copyback=2, 0x21 program=3, 0x22 read=4. The low byte is passed on `op_pp_o`. The bank and pointers are passed on their own outputs.
- R4: Flag bit 1 replaces the descriptor's flash pointer with the continuation flash address, and flag bit 0 does the same for the memory pointer. Accepting an erase, copyback, program or read advances the flash continuation to the pointer sent plus PP+1. Accepting a program or read also advances the memory continuation to the pointer sent plus (PP+1)·PAGE_BYTES.
- R5: A descriptor whose fetched status has bit 15 set is neither dispatched nor written back. Only its continue flag decides what happens next.
- R6: After execution, the status word is written to descriptor address + 32. It has bit 15 set. Bit 14 is set on engine failure, with the engine's operation index in [31:24]. All bits other than [31:24], 16, 15, 14 and 0 are zero.
- R7: On an engine bus error, the status has bits 16 and 14 set, and [31:24] keeps the value fetched from the descriptor.
- R8: A reserved command type is not dispatched. This includes a reset with PP greater than 2, and 0xFF with a low byte other than 0xFF. Its status is written with bits 15, 14 and 0 set, and the chain then stops even if the continue flag is set.
- R9: Command type 0xFFFF is not dispatched, and its status is written with only bit 15 set plus the preserved [31:24].
- R10: If flag bit 8 is set, `irq_comp_o[thread]` pulses for one cycle right after the status write is accepted. No other bit of `irq_comp_o` is raised.
- R11: If flag bit 9 is set after a descriptor, the next fetch is at its next pointer. Otherwise the block returns to idle.
- R12: A read beat with `rd_err_i` high stops the chain at once, pulses `irq_err_o`, and attempts no status write.
- R13: `op_valid_o` and the operation fields hold until `op_ready_i`. At most one of `rd_req_o`, `wr_req_o` and `op_valid_o` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command words valid |
| cmd0_i | input | 32 | Mode [31:30] and thread [26:24] |
| cmd2_i | input | 32 | Head address low word |
| cmd3_i | input | 32 | Head address high word |
| busy_o | output | 1 | Chain in progress |
| rd_req_o | output | 1 | Descriptor burst read request |
| rd_addr_o | output | ADDR_W | Descriptor address |
| rd_ack_i | input | 1 | Read request accepted |
| rd_data_valid_i | input | 1 | Read beat valid |
| rd_data_i | input | 64 | Read beat data |
| rd_err_i | input | 1 | Bus error on this beat |
| wr_req_o | output | 1 | Status write request |
| wr_addr_o | output | ADDR_W | Status word address |
| wr_data_o | output | 64 | Status word |
| wr_ack_i | input | 1 | Write accepted |
| wr_err_i | input | 1 | Bus error on the write |
| op_valid_o | output | 1 | Operation for the engine |
| op_kind_o | output | 3 | Operation kind |
| op_pp_o | output | 8 | Count minus one |
| op_bank_o | output | BANK_W | Target bank |
| op_flash_o | output | FLASH_W | Resolved flash address |
| op_mem_o | output | ADDR_W | Resolved memory address |
| op_ready_i | input | 1 | Engine accepts the operation |
| done_valid_i | input | 1 | Engine result valid |
| done_fail_i | input | 1 | Operation failed |
| done_bus_err_i | input | 1 | System bus error during operation |
| done_idx_i | input | 8 | Index of the first failing operation |
| irq_comp_o | output | 8 | Per-thread completion pulse |
| irq_err_o | output | 1 | Fetch or writeback bus error pulse |

## Verification
A wrong continuation register shows up on the very next dispatch. That dispatch carries a flash or memory address that is off by the page count or the page stride, so a two-descriptor chain exposes it within one fetch. A mis-latched status or command beat shows up within one descriptor. It produces the wrong `op_kind_o`, a skipped descriptor that gets written anyway, or a status word with wrong bits at descriptor + 32. A stale thread or flag register shows up as an interrupt on the wrong line, or as an extra or missing fetch, within a cycle of the status write.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    OP_ERASE = 3'd0, OP_RESET = 3'd1, OP_COPY = 3'd2, OP_PROG = 3'd3,
    OP_READ  = 3'd4, OP_NOP   = 3'd5, OP_BAD  = 3'd6
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FDATA, S_DISP, S_WAIT, S_WB, S_NEXT
  } seq_state_e;

  localparam int THR_W      = 3;
  localparam int FLG_MEMC   = 0;
  localparam int FLG_FLC    = 1;
  localparam int FLG_INT    = 8;
  localparam int FLG_CONT   = 9;
  localparam int ST_DESCERR = 0;
  localparam int ST_FAIL    = 14;
  localparam int ST_DONE    = 15;
  localparam int ST_BUSERR  = 16;
  localparam int ITEM_NEXT  = 0;
  localparam int ITEM_FLASH = 1;
  localparam int ITEM_CTL   = 2;
  localparam int ITEM_MEM   = 3;
  localparam int ITEM_STAT  = 4;
endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import flash_seq_pkg::*;
(
  input  logic [15:0] ctype_i,
  output op_kind_e    kind_o,
  output logic [7:0]  pp_o
);
  always_comb begin
    pp_o = ctype_i[7:0];
    case (ctype_i[15:8])
      8'h10:   kind_o = OP_ERASE;
      8'h11:   kind_o = (ctype_i[7:0] <= 8'd2) ? OP_RESET : OP_BAD;
      8'h12:   kind_o = OP_COPY;
      8'h21:   kind_o = OP_PROG;
      8'h22:   kind_o = OP_READ;
      8'hFF:   kind_o = (ctype_i[7:0] == 8'hFF) ? OP_NOP : OP_BAD;
      default: kind_o = OP_BAD;
    endcase
  end
endmodule

// File: rtl/fseq_ptr.sv
module fseq_ptr
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int FLASH_W = 32,
  parameter int PAGE_SH = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FLASH_W-1:0] flash_i,
  input  logic [ADDR_W-1:0]  mem_i,
  input  logic               flash_cont_i,
  input  logic               mem_cont_i,
  input  op_kind_e           kind_i,
  input  logic [7:0]         pp_i,
  input  logic               adv_i,
  output logic [FLASH_W-1:0] flash_o,
  output logic [ADDR_W-1:0]  mem_o
);
  logic [FLASH_W-1:0] fl_q;
  logic [ADDR_W-1:0]  mem_q;
  logic [FLASH_W-1:0] fl_step;
  logic [ADDR_W-1:0]  mem_step;
  logic               moves_flash, moves_mem;

  assign flash_o     = flash_cont_i ? fl_q : flash_i;
  assign mem_o       = mem_cont_i ? mem_q : mem_i;
  assign fl_step     = FLASH_W'(pp_i) + FLASH_W'(1);
  assign mem_step    = (ADDR_W'(pp_i) + ADDR_W'(1)) << PAGE_SH;
  assign moves_mem   = (kind_i == OP_PROG) || (kind_i == OP_READ);
  assign moves_flash = moves_mem || (kind_i == OP_ERASE) || (kind_i == OP_COPY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q  <= '0;
      mem_q <= '0;
    end else if (adv_i) begin
      if (moves_flash) fl_q <= flash_o + fl_step;
      if (moves_mem)   mem_q <= mem_o + mem_step;
    end
  end
endmodule

// File: rtl/fseq_status.sv
module fseq_status
  import flash_seq_pkg::*;
(
  input  logic [63:0] old_i,
  input  logic        fail_i,
  input  logic        bus_i,
  input  logic        bad_i,
  input  logic [7:0]  idx_i,
  output logic [63:0] word_o
);
  always_comb begin
    word_o             = '0;
    word_o[31:24]      = (fail_i && !bus_i) ? idx_i : old_i[31:24];
    word_o[ST_BUSERR]  = bus_i;
    word_o[ST_DONE]    = 1'b1;
    word_o[ST_FAIL]    = fail_i | bus_i | bad_i;
    word_o[ST_DESCERR] = bad_i;
  end
endmodule

// File: rtl/flash_desc_seq.sv
module flash_desc_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int FLASH_W    = 32,
  parameter int BANK_W     = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int DESC_BEATS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [31:0]           cmd0_i,
  input  logic [31:0]           cmd2_i,
  input  logic [31:0]           cmd3_i,
  output logic                  busy_o,
  output logic                  rd_req_o,
  output logic [ADDR_W-1:0]     rd_addr_o,
  input  logic                  rd_ack_i,
  input  logic                  rd_data_valid_i,
  input  logic [63:0]           rd_data_i,
  input  logic                  rd_err_i,
  output logic                  wr_req_o,
  output logic [ADDR_W-1:0]     wr_addr_o,
  output logic [63:0]           wr_data_o,
  input  logic                  wr_ack_i,
  input  logic                  wr_err_i,
  output logic                  op_valid_o,
  output logic [2:0]            op_kind_o,
  output logic [7:0]            op_pp_o,
  output logic [BANK_W-1:0]     op_bank_o,
  output logic [FLASH_W-1:0]    op_flash_o,
  output logic [ADDR_W-1:0]     op_mem_o,
  input  logic                  op_ready_i,
  input  logic                  done_valid_i,
  input  logic                  done_fail_i,
  input  logic                  done_bus_err_i,
  input  logic [7:0]            done_idx_i,
  output logic [(1<<THR_W)-1:0] irq_comp_o,
  output logic                  irq_err_o
);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);
  localparam int BEAT_W  = $clog2(DESC_BEATS);
  localparam int N_THR   = 1 << THR_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(DESC_BEATS - 1);
  localparam logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'(ITEM_STAT * 8);

  seq_state_e         state_q;
  logic [ADDR_W-1:0]  cur_q, it_next, it_mem;
  logic [THR_W-1:0]   thr_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [FLASH_W-1:0] it_flash;
  logic [BANK_W-1:0]  it_bank;
  logic [15:0]        it_ctype, it_flags;
  logic [63:0]        it_stat;
  logic               res_fail_q, res_bus_q;
  logic [7:0]         res_idx_q;
  logic [N_THR-1:0]   irq_comp_q;
  logic               irq_err_q;
  op_kind_e           kind;
  logic [7:0]         pp;

  fseq_decode i_decode (.ctype_i(it_ctype), .kind_o(kind), .pp_o(pp));

  fseq_ptr #(.ADDR_W(ADDR_W), .FLASH_W(FLASH_W), .PAGE_SH(PAGE_SH)) i_ptr (
    .clk_i, .rst_ni,
    .flash_i(it_flash), .mem_i(it_mem),
    .flash_cont_i(it_flags[FLG_FLC]), .mem_cont_i(it_flags[FLG_MEMC]),
    .kind_i(kind), .pp_i(pp),
    .adv_i(state_q == S_DISP && op_ready_i),
    .flash_o(op_flash_o), .mem_o(op_mem_o)
  );

  fseq_status i_status (
    .old_i(it_stat), .fail_i(res_fail_q), .bus_i(res_bus_q),
    .bad_i(kind == OP_BAD), .idx_i(res_idx_q), .word_o(wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cur_q      <= '0;
      thr_q      <= '0;
      beat_q     <= '0;
      it_next    <= '0;
      it_mem     <= '0;
      it_flash   <= '0;
      it_bank    <= '0;
      it_ctype   <= '0;
      it_flags   <= '0;
      it_stat    <= '0;
      res_fail_q <= 1'b0;
      res_bus_q  <= 1'b0;
      res_idx_q  <= '0;
      irq_comp_q <= '0;
      irq_err_q  <= 1'b0;
    end else begin
      irq_comp_q <= '0;
      irq_err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (cmd_valid_i && cmd0_i[31:30] == 2'b00) begin
          cur_q   <= ADDR_W'({cmd3_i, cmd2_i});
          thr_q   <= cmd0_i[26:24];
          state_q <= S_FREQ;
        end
        S_FREQ: if (rd_ack_i) begin
          beat_q  <= '0;
          state_q <= S_FDATA;
        end
        S_FDATA: if (rd_data_valid_i) begin
          if (rd_err_i) begin
            irq_err_q <= 1'b1;
            state_q   <= S_IDLE;
          end else begin
            case (beat_q)
              BEAT_W'(ITEM_NEXT):  it_next <= ADDR_W'(rd_data_i);
              BEAT_W'(ITEM_FLASH): begin
                it_flash <= rd_data_i[FLASH_W-1:0];
                it_bank  <= rd_data_i[32 +: BANK_W];
              end
              BEAT_W'(ITEM_CTL): begin
                it_ctype <= rd_data_i[15:0];
                it_flags <= rd_data_i[47:32];
              end
              BEAT_W'(ITEM_MEM):   it_mem  <= ADDR_W'(rd_data_i);
              BEAT_W'(ITEM_STAT):  it_stat <= rd_data_i;
              default: ;
            endcase
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) begin
              res_fail_q <= 1'b0;
              res_bus_q  <= 1'b0;
              res_idx_q  <= '0;
              if (it_stat[ST_DONE])                      state_q <= S_NEXT;
              else if (kind == OP_NOP || kind == OP_BAD) state_q <= S_WB;
              else                                       state_q <= S_DISP;
            end
          end
        end
        S_DISP: if (op_ready_i) state_q <= S_WAIT;
        S_WAIT: if (done_valid_i) begin
          res_fail_q <= done_fail_i;
          res_bus_q  <= done_bus_err_i;
          res_idx_q  <= done_idx_i;
          state_q    <= S_WB;
        end
        S_WB: if (wr_ack_i) begin
          if (wr_err_i) begin
            irq_err_q <= 1'b1;
            state_q   <= S_IDLE;
          end else begin
            if (it_flags[FLG_INT]) irq_comp_q[thr_q] <= 1'b1;
            state_q <= (kind == OP_BAD) ? S_IDLE : S_NEXT;
          end
        end
        S_NEXT: if (it_flags[FLG_CONT]) begin
          cur_q   <= it_next;
          state_q <= S_FREQ;
        end else begin
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != S_IDLE;
  assign rd_req_o   = state_q == S_FREQ;
  assign rd_addr_o  = cur_q;
  assign wr_req_o   = state_q == S_WB;
  assign wr_addr_o  = cur_q + STAT_OFS;
  assign op_valid_o = state_q == S_DISP;
  assign op_kind_o  = kind;
  assign op_pp_o    = pp;
  assign op_bank_o  = it_bank;
  assign irq_comp_o = irq_comp_q;
  assign irq_err_o  = irq_err_q;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int ADDR_W  = 64,
  parameter int FLASH_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               rd_req_o,
  input logic [ADDR_W-1:0]  rd_addr_o,
  input logic               rd_ack_i,
  input logic               wr_req_o,
  input logic [63:0]        wr_data_o,
  input logic               wr_ack_i,
  input logic               op_valid_o,
  input logic [2:0]         op_kind_o,
  input logic [FLASH_W-1:0] op_flash_o,
  input logic [ADDR_W-1:0]  op_mem_o,
  input logic               op_ready_i,
  input logic [7:0]         irq_comp_o,
  input logic               irq_err_o
);
  assert_one_master_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, wr_req_o, op_valid_o}));

  assert_op_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && !op_ready_i |=> op_valid_o && $stable(op_flash_o)
                                 && $stable(op_mem_o) && $stable(op_kind_o));

  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

  assert_wb_complete_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_data_o[15]);

  assert_irq_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_comp_o));

  assert_irq_after_wb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_comp_o) |-> $past(wr_req_o && wr_ack_i));

  assert_err_stop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |-> !busy_o);
endmodule

bind flash_desc_seq fseq_checker #(.ADDR_W(ADDR_W), .FLASH_W(FLASH_W)) i_fseq_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .rd_req_o(rd_req_o),
  .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .wr_req_o(wr_req_o),
  .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .op_valid_o(op_valid_o),
  .op_kind_o(op_kind_o), .op_flash_o(op_flash_o), .op_mem_o(op_mem_o),
  .op_ready_i(op_ready_i), .irq_comp_o(irq_comp_o), .irq_err_o(irq_err_o)
);

// File: tb/test_flash_desc_seq.sv
`timescale 1ns/1ps
module test_flash_desc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd0_i = '0, cmd2_i = '0, cmd3_i = '0;
  logic        busy_o, rd_req_o, wr_req_o, op_valid_o, irq_err_o;
  logic [63:0] rd_addr_o, wr_addr_o, wr_data_o, op_mem_o;
  logic        rd_ack_i = 1'b0, rd_data_valid_i = 1'b0, rd_err_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic        wr_ack_i = 1'b0, wr_err_i = 1'b0;
  logic [2:0]  op_kind_o;
  logic [7:0]  op_pp_o;
  logic [15:0] op_bank_o;
  logic [31:0] op_flash_o;
  logic        op_ready_i = 1'b0, done_valid_i = 1'b0, done_fail_i = 1'b0, done_bus_err_i = 1'b0;
  logic [7:0]  done_idx_i = '0;
  logic [7:0]  irq_comp_o;

  always #2 clk = ~clk;

  flash_desc_seq i_flash_desc_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i, .cmd0_i, .cmd2_i, .cmd3_i, .busy_o,
    .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_valid_i, .rd_data_i, .rd_err_i,
    .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ack_i, .wr_err_i,
    .op_valid_o, .op_kind_o, .op_pp_o, .op_bank_o, .op_flash_o, .op_mem_o, .op_ready_i,
    .done_valid_i, .done_fail_i, .done_bus_err_i, .done_idx_i, .irq_comp_o, .irq_err_o
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] mem [0:127];
  logic [63:0] err_addr = 64'hFFFF_FFFF;
  logic        eng_fail = 1'b0, eng_bus = 1'b0;
  logic [7:0]  eng_idx = '0;
  int n_ops, n_rd, n_wr, n_irq, n_err;
  logic [7:0]  irq_bits;
  logic [2:0]  l_kind [0:15];
  logic [7:0]  l_pp [0:15];
  logic [15:0] l_bank [0:15];
  logic [31:0] l_flash [0:15];
  logic [63:0] l_mem [0:15];
  logic [63:0] l_rd [0:15];
  int rd_left = 0, eng_t = 0;
  logic [63:0] rd_ptr = '0;

  localparam logic [15:0] F_MEMC = 16'h0001, F_FLC = 16'h0002, F_INT = 16'h0100, F_CONT = 16'h0200;

  // responders drive on the falling edge
  always @(negedge clk) begin
    logic pr, pw, po;
    pr = rd_ack_i; pw = wr_ack_i; po = op_ready_i;
    rd_ack_i = 0; rd_data_valid_i = 0; rd_err_i = 0; wr_ack_i = 0; wr_err_i = 0;
    op_ready_i = 0; done_valid_i = 0;
    if (rd_left > 0) begin
      rd_data_valid_i = 1; rd_data_i = mem[rd_ptr[9:3]];
      rd_err_i = (rd_ptr == err_addr); rd_ptr += 8; rd_left--;
    end else if (rd_req_o && !pr) begin
      rd_ack_i = 1; rd_left = 8; rd_ptr = rd_addr_o;
      if (n_rd < 16) l_rd[n_rd] = rd_addr_o;
      n_rd++;
    end
    if (wr_req_o && !pw) begin
      wr_ack_i = 1; mem[wr_addr_o[9:3]] = wr_data_o; n_wr++;
    end
    if (op_valid_o && !po) begin
      op_ready_i = 1; eng_t = 3;
      if (n_ops < 16) begin
        l_kind[n_ops] = op_kind_o; l_pp[n_ops] = op_pp_o; l_bank[n_ops] = op_bank_o;
        l_flash[n_ops] = op_flash_o; l_mem[n_ops] = op_mem_o;
      end
      n_ops++;
    end else if (eng_t > 0) begin
      eng_t--;
      if (eng_t == 0) begin
        done_valid_i = 1; done_fail_i = eng_fail; done_bus_err_i = eng_bus; done_idx_i = eng_idx;
      end
    end
    if (irq_comp_o != 0) begin n_irq++; irq_bits |= irq_comp_o; end
    if (irq_err_o) n_err++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R13 watchdog expired actual=%0d expected<=100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic clear_logs();
    n_ops = 0; n_rd = 0; n_wr = 0; n_irq = 0; n_err = 0; irq_bits = '0;
    eng_fail = 0; eng_bus = 0; eng_idx = '0; err_addr = 64'hFFFF_FFFF;
    for (int i = 0; i < 128; i++) mem[i] = '0;
  endtask

  task automatic put_desc(input logic [63:0] a, input logic [63:0] nxt, input logic [15:0] bank,
                          input logic [31:0] fl, input logic [15:0] flags, input logic [15:0] ct,
                          input logic [63:0] mp, input logic [63:0] st);
    mem[a[9:3] + 0] = nxt;
    mem[a[9:3] + 1] = {16'h0, bank, fl};
    mem[a[9:3] + 2] = {16'h0, flags, 16'h0, ct};
    mem[a[9:3] + 3] = mp;
    mem[a[9:3] + 4] = st;
  endtask

  task automatic run_chain(input logic [1:0] mode, input logic [2:0] thr, input logic [63:0] head);
    @(negedge clk);
    cmd0_i = {mode, 3'b000, thr, 24'h0}; cmd2_i = head[31:0]; cmd3_i = head[63:32];
    cmd_valid_i = 1;
    @(negedge clk);
    cmd_valid_i = 0;
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    eq("R1 reset busy", busy_o, 0);
    eq("R13 reset requests", {rd_req_o, wr_req_o, op_valid_o}, 0);
    eq("R10 reset irq", {irq_comp_o, irq_err_o}, 0);
  endtask

  task automatic t_bad_mode();
    clear_logs();
    put_desc(0, 0, 0, 0, 0, 16'hFFFF, 0, 0);
    @(negedge clk);
    cmd0_i = 32'h4100_0000; cmd_valid_i = 1;
    @(negedge clk);
    cmd_valid_i = 0;
    eq("R1 other mode keeps busy low", busy_o, 0);
    repeat (5) @(negedge clk);
    eq("R1 other mode no fetch", n_rd, 0);
  endtask

  task automatic t_chain();
    clear_logs();
    put_desc(64'h000, 64'h040, 16'h0, 32'h100, F_CONT | F_INT, 16'h2201, 64'h10000, 0);
    put_desc(64'h040, 64'h080, 16'h0, 32'hDEAD, F_CONT | F_FLC | F_MEMC, 16'h2100, 64'h9999_9000, 0);
    put_desc(64'h080, 64'h000, 16'h1, 32'h500, F_INT, 16'h1003, 64'h0, 0);
    run_chain(2'b00, 3'd5, 64'h0);
    eq("R11 three fetches", n_rd, 3);
    eq("R2 fetch addr 1", l_rd[1], 64'h040);
    eq("R2 fetch addr 2", l_rd[2], 64'h080);
    eq("R3 op count", n_ops, 3);
    eq("R3 read kind", l_kind[0], 4);
    eq("R3 read pp", l_pp[0], 1);
    eq("R3 read flash", l_flash[0], 32'h100);
    eq("R3 read mem", l_mem[0], 64'h10000);
    eq("R4 program kind", l_kind[1], 3);
    eq("R4 flash continued", l_flash[1], 32'h102);
    eq("R4 mem continued", l_mem[1], 64'h12000);
    eq("R3 erase kind", l_kind[2], 0);
    eq("R3 erase bank", l_bank[2], 1);
    eq("R3 erase flash", l_flash[2], 32'h500);
    eq("R6 status 0", mem[4], 64'h8000);
    eq("R6 status 1", mem[12], 64'h8000);
    eq("R6 status 2", mem[20], 64'h8000);
    eq("R10 irq count", n_irq, 2);
    eq("R10 irq thread", irq_bits, 8'h20);
    eq("R11 idle after last", busy_o, 0);
  endtask

  task automatic t_skip_nop();
    clear_logs();
    put_desc(64'h0C0, 64'h100, 0, 32'h1, F_CONT | F_INT, 16'h2200, 64'h0, 64'h5500_8000);
    put_desc(64'h100, 64'h0, 0, 32'h0, F_INT, 16'hFFFF, 64'h0, 64'h7700_0000);
    run_chain(2'b00, 3'd2, 64'h0C0);
    eq("R5 skip no dispatch", n_ops, 0);
    eq("R5 skip followed continue", n_rd, 2);
    eq("R5 skipped status untouched", mem[28], 64'h5500_8000);
    eq("R9 nop status", mem[36], 64'h7700_8000);
    eq("R9 single write", n_wr, 1);
    eq("R10 irq only from nop", n_irq, 1);
    eq("R10 irq line", irq_bits, 8'h04);
  endtask

  task automatic t_fail();
    clear_logs();
    put_desc(64'h0, 64'h0, 0, 32'h10, F_INT, 16'h2200, 64'h0, 64'h1100_0000);
    eng_fail = 1; eng_idx = 8'd3;
    run_chain(2'b00, 3'd0, 64'h0);
    eq("R6 fail status", mem[4], 64'h0300_C000);
    eq("R10 irq on fail", irq_bits, 8'h01);
  endtask

  task automatic t_bus();
    clear_logs();
    put_desc(64'h0, 64'h0, 0, 32'h10, 0, 16'h2100, 64'h0, 64'h0700_0000);
    eng_bus = 1; eng_idx = 8'd9;
    run_chain(2'b00, 3'd1, 64'h0);
    eq("R7 bus error status", mem[4], 64'h0701_C000);
    eq("R10 no irq without flag", n_irq, 0);
  endtask

  task automatic t_reserved();
    clear_logs();
    put_desc(64'h0, 64'h040, 0, 32'h0, F_CONT, 16'h3300, 64'h0, 64'h0);
    put_desc(64'h040, 64'h0, 0, 32'h0, 0, 16'h2200, 64'h0, 64'h0);
    run_chain(2'b00, 3'd0, 64'h0);
    eq("R8 reserved status", mem[4], 64'hC001);
    eq("R8 no dispatch", n_ops, 0);
    eq("R8 chain stopped", n_rd, 1);
    clear_logs();
    put_desc(64'h0, 64'h0, 0, 32'h0, 0, 16'h1105, 64'h0, 64'h0);
    run_chain(2'b00, 3'd0, 64'h0);
    eq("R8 bad reset type status", mem[4], 64'hC001);
    eq("R8 bad reset no dispatch", n_ops, 0);
  endtask

  task automatic t_fetch_err();
    clear_logs();
    put_desc(64'h0, 64'h040, 0, 32'h0, F_CONT | F_INT, 16'h2200, 64'h0, 64'h0);
    err_addr = 64'h8;
    run_chain(2'b00, 3'd0, 64'h0);
    eq("R12 err irq", n_err, 1);
    eq("R12 no write", n_wr, 0);
    eq("R12 no dispatch", n_ops, 0);
    eq("R12 stopped", busy_o, 0);
  endtask

  task automatic t_kinds();
    clear_logs();
    put_desc(64'h0, 64'h040, 16'h3, 32'h20, F_CONT, 16'h1102, 64'h0, 64'h0);
    put_desc(64'h040, 64'h0, 0, 32'h40, 0, 16'h1204, 64'h0, 64'h0);
    run_chain(2'b00, 3'd7, 64'h0);
    eq("R3 reset kind", l_kind[0], 1);
    eq("R3 reset pp", l_pp[0], 2);
    eq("R3 reset bank", l_bank[0], 3);
    eq("R3 copyback kind", l_kind[1], 2);
    eq("R3 copyback pp", l_pp[1], 4);
  endtask

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_bad_mode();
    t_chain();
    t_skip_nop();
    t_fail();
    t_bus();
    t_reserved();
    t_fetch_err();
    t_kinds();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule